// File: doc/BRIEF.md
# Sinc-Weighted Shift-Register Summer

This block turns the 24 parallel bits of a pseudo-random shift register into a multi-level, zero-mean stepped value whose spectrum is flat across its band, so that after conversion it approximates Gaussian white noise. Each register bit stands for +1 when set and −1 when clear. Each bit is scaled by a fixed signed weight taken from a sin(x)/x curve, and the scaled values are summed.

The weight curve is symmetric about the middle of the register. Bits that mirror each other therefore share one coefficient. The two bits of each mirrored pair are combined before weighting, which leaves only 12 coefficients. The curve crosses zero at the two positions 6.5 steps from the centre, so those two bits carry no weight. A new register state arrives with a valid strobe. Its sum leaves a three-stage adder pipeline with a valid flag of its own, and between results the output holds its last value.

Top module: `sinc_noise_summer`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid and out_sum are 0 after that edge.
- R2: out_valid is high exactly 3 clock edges after the edge that sampled in_valid high, and is low otherwise.
- R3: Bit i of in_state (bit 0 = LSB) counts as +1 when 1 and −1 when 0, and is weighted by w[i]. From bit 0 to bit 23 the weights are −62, −95, −112, −103, −66, 0, 90, 195, 303, 399, 472, 511, 511, 472, 399, 303, 195, 90, 0, −66, −103, −112, −95, −62. out_sum is the two's-complement sum of these terms, so all-ones gives +3064 and all-zeros gives −3064.
- R4: The weights are mirror-symmetric: reversing the bit order of in_state gives the same out_sum.
- R5: Bits 5 and 18 have zero weight, and toggling them never changes out_sum.
- R6: Toggling a single bit i from 0 to 1 raises out_sum by exactly 2·w[i].
- R7: |out_sum| never exceeds 4816. Exactly +4816 is reached for in_state = 0x03FFC0 and −4816 for 0xFC003F, without overflow.
- R8: In a cycle where out_valid is low, out_sum keeps its previous value.
- R9: States presented on consecutive cycles each yield their own result, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | in_state carries a new register state this cycle |
| in_state | input | 24 | Parallel shift-register bits |
| out_valid | output | 1 | out_sum carries a new result this cycle |
| out_sum | output | 14 | Signed weighted sum, two's complement |

## Verification
A new state can be accepted in the same cycle as the result of a state taken three cycles earlier leaves the pipeline. The bench provokes this by streaming states on back-to-back cycles, so input capture, the middle stages and the output register are all busy at once. Each emerging result is checked against the weighted sum of the state that was presented three cycles earlier, and out_valid must be high on every cycle of the stream. Separate hold tests confirm that idle cycles leave out_sum frozen.

// File: rtl/sinc_noise_pkg.sv
// Package: shared constants and the sinc coefficient table for the summer.
// Assumes a 24-bit register. Pair p joins bits (11-p) and (12+p).
package sinc_noise_pkg;
    localparam int N_TAPS  = 24;
    localparam int N_PAIRS = N_TAPS / 2;
    localparam int COEF_W  = 10;

    // Returns the shared coefficient of mirrored pair p (0 = centre pair).
    function automatic logic signed [COEF_W-1:0] pair_coef(input int p);
        case (p)
            0:       return 10'sd511;
            1:       return 10'sd472;
            2:       return 10'sd399;
            3:       return 10'sd303;
            4:       return 10'sd195;
            5:       return 10'sd90;
            6:       return 10'sd0;
            7:       return -10'sd66;
            8:       return -10'sd103;
            9:       return -10'sd112;
            10:      return -10'sd95;
            11:      return -10'sd62;
            default: return 10'sd0;
        endcase
    endfunction

    // Worst-case output magnitude: each pair contributes at most 2*|c|.
    function automatic int max_magnitude();
        int acc;
        acc = 0;
        for (int p = 0; p < N_PAIRS; p++) begin
            acc += 2 * ((pair_coef(p) < 0) ? -int'(pair_coef(p)) : int'(pair_coef(p)));
        end
        return acc;
    endfunction
endpackage

// File: rtl/sinc_pair_weight.sv
// Module: sinc_pair_weight
// Weights one mirrored bit pair by its shared coefficient. Each bit counts as
// +1 (set) or -1 (clear), so the pair sum is -2, 0 or +2 and the product is
// -2c, 0 or +2c. Purely combinational.
module sinc_pair_weight #(
    parameter int COEF_W = 10,
    parameter int PROD_W = COEF_W + 2
) (
    input  logic                     bit_lo,
    input  logic                     bit_hi,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [PROD_W-1:0] prod
);
    logic signed [PROD_W-1:0] twice;

    // Doubles the coefficient at product width.
    always_comb twice = PROD_W'(coef) <<< 1;

    // Selects +2c, -2c or 0 from the pair's two bits.
    always_comb begin
        case ({bit_hi, bit_lo})
            2'b11:   prod = twice;
            2'b00:   prod = -twice;
            default: prod = '0;
        endcase
    end
endmodule

// File: rtl/sinc_group_adder.sv
// Module: sinc_group_adder
// Adds N signed terms of width IN_W into one signed result of width OUT_W.
// Assumes OUT_W is wide enough for the caller's worst case. Combinational.
module sinc_group_adder #(
    parameter int N     = 4,
    parameter int IN_W  = 12,
    parameter int OUT_W = 14
) (
    input  logic [N-1:0][IN_W-1:0] terms,
    output logic signed [OUT_W-1:0] total
);
    // Sign-extends and accumulates every term.
    always_comb begin
        total = '0;
        for (int k = 0; k < N; k++) begin
            total = total + OUT_W'($signed(terms[k]));
        end
    end
endmodule

// File: rtl/sinc_noise_summer.sv
// Module: sinc_noise_summer (top)
// Weighted sum of a 24-bit register state with a symmetric sinc weight set.
// Stage 1 registers the 12 pair products, stage 2 the group partial sums,
// stage 3 the final sum. Latency from in_valid to out_valid is 3 clocks.
// Each stage loads only when its valid is set, so results hold between
// strobes. Assumes N_PAIRS is a multiple of GROUP.
module sinc_noise_summer
    import sinc_noise_pkg::*;
#(
    parameter int SUM_W = 14,
    parameter int GROUP = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [N_TAPS-1:0]       in_state,
    output logic                    out_valid,
    output logic signed [SUM_W-1:0] out_sum
);
    localparam int PROD_W = COEF_W + 2;
    localparam int N_GRP  = N_PAIRS / GROUP;

    logic [N_PAIRS-1:0][PROD_W-1:0] prod_c;
    logic [N_PAIRS-1:0][PROD_W-1:0] prod_q;
    logic [N_GRP-1:0][SUM_W-1:0]    part_c;
    logic [N_GRP-1:0][SUM_W-1:0]    part_q;
    logic signed [SUM_W-1:0]        total_c;
    logic                           v1_q, v2_q;

    // One weight unit per mirrored pair.
    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        logic signed [PROD_W-1:0] w_prod;
        sinc_pair_weight #(.COEF_W(COEF_W), .PROD_W(PROD_W)) u_w (
            .bit_lo (in_state[N_PAIRS-1-p]),
            .bit_hi (in_state[N_PAIRS+p]),
            .coef   (pair_coef(p)),
            .prod   (w_prod)
        );
        assign prod_c[p] = w_prod;
    end

    // One partial adder per group of GROUP pair products.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic signed [SUM_W-1:0] g_total;
        sinc_group_adder #(.N(GROUP), .IN_W(PROD_W), .OUT_W(SUM_W)) u_add (
            .terms (prod_q[g*GROUP +: GROUP]),
            .total (g_total)
        );
        assign part_c[g] = g_total;
    end

    // Final adder over the group partial sums.
    sinc_group_adder #(.N(N_GRP), .IN_W(SUM_W), .OUT_W(SUM_W)) u_final (
        .terms (part_q),
        .total (total_c)
    );

    // Stage 1: capture pair products when a new state arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            v1_q   <= 1'b0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) prod_q <= prod_c;
        end
    end

    // Stage 2: capture group partial sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            v2_q   <= 1'b0;
        end else begin
            v2_q <= v1_q;
            if (v1_q) part_q <= part_c;
        end
    end

    // Stage 3: capture the final sum and raise the output strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sum   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= v2_q;
            if (v2_q) out_sum <= total_c;
        end
    end
endmodule

// File: rtl/sinc_noise_summer_chk.sv
// Module: sinc_noise_summer_chk
// Checker bound to the summer. Observes its ports only.
module sinc_noise_summer_chk
    import sinc_noise_pkg::*;
#(
    parameter int SUM_W = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [SUM_W-1:0] out_sum
);
    localparam int MAXM = max_magnitude();

    // R1: reset clears the outputs on the next edge.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sum == '0));

    // R2: a sampled strobe yields an output strobe three edges later.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // R7: the result stays inside the worst-case magnitude.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(out_sum) <= MAXM) && (int'(out_sum) >= -MAXM));

    // R8: no strobe means no change of the sum.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> $stable(out_sum));
endmodule

bind sinc_noise_summer sinc_noise_summer_chk #(.SUM_W(SUM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sum   (out_sum)
);

// File: tb/sinc_noise_summer_bench.sv
module sinc_noise_summer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_state = '0;
    logic        out_valid;
    logic signed [13:0] out_sum;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    sinc_noise_summer u_sinc_noise_summer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_state(in_state),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    function automatic int wt(input int i);
        int t[24] = '{-62, -95, -112, -103, -66, 0, 90, 195, 303, 399, 472, 511,
                      511, 472, 399, 303, 195, 90, 0, -66, -103, -112, -95, -62};
        return t[i];
    endfunction

    function automatic int ref_sum(input logic [23:0] s);
        int acc = 0;
        for (int i = 0; i < 24; i++) acc += s[i] ? wt(i) : -wt(i);
        return acc;
    endfunction

    function automatic logic [23:0] mirror(input logic [23:0] s);
        logic [23:0] r;
        for (int i = 0; i < 24; i++) r[i] = s[23-i];
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Presents one state and returns its result; checks the strobe timing (R2).
    task automatic run_one(input logic [23:0] s, output int res);
        @(negedge clk); in_valid = 1'b1; in_state = s;
        @(negedge clk); in_valid = 1'b0;
        check("R2 early", int'(out_valid), 0);
        @(negedge clk);
        check("R2 early", int'(out_valid), 0);
        @(negedge clk);
        check("R2 strobe", int'(out_valid), 1);
        res = int'(out_sum);
        @(negedge clk);
        check("R2 single", int'(out_valid), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid", int'(out_valid), 0);
        check("R1 sum", int'(out_sum), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_extremes();
        int r;
        run_one(24'hFFFFFF, r); check("R3 all ones", r, 3064);
        run_one(24'h000000, r); check("R3 all zeros", r, -3064);
        run_one(24'h5A3C96, r); check("R3 pattern", r, ref_sum(24'h5A3C96));
        run_one(24'h03FFC0, r); check("R7 max", r, 4816);
        run_one(24'hFC003F, r); check("R7 min", r, -4816);
    endtask

    task automatic t_mirror();
        int a, b;
        logic [23:0] s = 24'h8C1E47;
        run_one(s, a);
        run_one(mirror(s), b);
        check("R4 mirror", b, a);
        check("R4 value", a, ref_sum(s));
    endtask

    task automatic t_zero_taps();
        int a, b;
        run_one(24'h3A0C11, a);
        run_one(24'h3A0C11 ^ 24'h040020, b);
        check("R5 bits 5 and 18", b, a);
    endtask

    task automatic t_single_bit();
        int r;
        run_one(24'h000800, r); check("R6 bit 11", r, -3064 + 1022);
        run_one(24'h000001, r); check("R6 bit 0", r, -3064 - 124);
        run_one(24'h100000, r); check("R6 bit 20", r, -3064 - 206);
    endtask

    task automatic t_hold();
        int r;
        run_one(24'h00F00F, r);
        repeat (4) @(negedge clk);
        check("R8 hold", int'(out_sum), ref_sum(24'h00F00F));
        in_state = 24'hFFFFFF;
        repeat (4) @(negedge clk);
        check("R8 ignore idle input", int'(out_sum), ref_sum(24'h00F00F));
    endtask

    task automatic t_stream();
        logic [23:0] st[8] = '{24'h123456, 24'hABCDEF, 24'h000000, 24'hFFFFFF,
                               24'h03FFC0, 24'h800001, 24'h0F0F0F, 24'hFC003F};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                check("R9 strobe", int'(out_valid), 1);
                check("R9 order", int'(out_sum), ref_sum(st[i-3]));
            end
            in_valid = (i < 8);
            if (i < 8) in_state = st[i];
        end
        @(negedge clk);
        check("R2 stream end", int'(out_valid), 0);
    endtask

    initial begin
        t_reset();
        t_extremes();
        t_mirror();
        t_zero_taps();
        t_single_bit();
        t_hold();
        t_stream();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule